// File: doc/BRIEF.md
# Time-Multiplexed Complex LMS Filter Element

This element runs a complex-tap adaptive FIR filter for several users in turn. Each user owns a vector of `NTAPS` complex coefficients, and all the vectors live in one local coefficient memory at offsets of `user * NTAPS`. A pass starts with a one-cycle `start` pulse that carries the user index, the mode and, for training, the known bit. The element then fetches the complex input vector one sample at a time. It drives a sample index on `smp_addr` and reads the sample back on `smp_re`/`smp_im` in the same cycle. The caller keeps the vector in a small buffer and holds it constant for the whole pass.

A detection pass computes the inner product of the conjugated coefficients with the samples and returns its real and imaginary parts. A training pass does the same filtering first. It then forms the error between the training symbol and the real output, and moves every tap by the error times the matching sample, scaled by a power-of-two step. Each complex product takes four real products, and these share two pipelined real multipliers over two cycles. Every pass has a fixed length, so a scheduler can interleave users without handshaking.

Top module: `tmux_cplx_lms`

## Requirements
- R1: After reset, `busy` and `out_valid` are low, `y_re`/`y_im` are zero, and every coefficient of every user is zero, so the first detection pass of any user returns 0.
- R2: A detection pass (`train_mode`=0) accepted at clock edge E0 keeps `busy` high and `out_valid` low until edge E0+2·NTAPS+4. At that edge `out_valid` rises for exactly one cycle and `busy` falls.
- R3: A training pass (`train_mode`=1) takes 2·NTAPS+4 filtering cycles plus 2·NTAPS+5 update cycles. `out_valid` pulses once, at edge E0+4·NTAPS+9.
- R4: With Q1.15 samples r and coefficients w, `y_re` = floor(Σ(w_re·r_re + w_im·r_im) / 2^15) and `y_im` = floor(Σ(w_re·r_im − w_im·r_re) / 2^15). Both are computed with the coefficients as they were at the start of the pass.
- R5: `y_re` and `y_im` clamp to the range −32768..32767 and never wrap.
- R6: Training uses a target of 32767 for `train_bit`=1 and −32768 for `train_bit`=0. The error is e = clamp16(target − y_re). Each tap becomes w_re ← clamp16(w_re + clamp16(floor(e·r_re / 2^(15+MU_SHIFT)))), and w_im is updated the same way with r_im.
- R7: A detection pass leaves the coefficients unchanged.
- R8: A pass reads and writes only the coefficients of the user given by `user_sel` when it was accepted. Other users are unaffected.
- R9: A `start` that arrives while `busy` is high is ignored. It neither alters the running pass nor starts another one.
- R10: `y_re` and `y_im` hold their value in every cycle in which `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a pass when `busy` is low |
| train_mode | input | 1 | 1 = filter then adapt, 0 = filter only; sampled with `start` |
| user_sel | input | UW | User whose coefficient vector is used; sampled with `start` |
| train_bit | input | 1 | Known symbol for training (1 → +1, 0 → −1); sampled with `start` |
| smp_addr | output | TW | Index of the sample being read |
| smp_re | input | DW | Real part of sample `smp_addr`, Q1.15 |
| smp_im | input | DW | Imaginary part of sample `smp_addr`, Q1.15 |
| busy | output | 1 | A pass is in progress |
| out_valid | output | 1 | One-cycle pulse at the end of a pass |
| y_re | output | DW | Real part of the filter output, Q1.15 |
| y_im | output | DW | Imaginary part of the filter output, Q1.15 |

## Verification
The bench trains users until their outputs run far past full scale on a larger vector. This checks clamping in both directions. A design that wraps would flip the sign of the output. It also trains once on a strongly wrong output so that the error term itself saturates. Without that clamp the update would run in the wrong direction.

A second `start` is injected in the middle of a pass. A design that honours it would change the pass length or change the coefficients of the poked user. User isolation is checked by detecting an untouched user, which must return 0, after another user has been trained. Pass length is compared on every cycle, so a schedule that is off by one cycle in either mode shows up at once.

// File: rtl/tcl_pkg.sv
package tcl_pkg;

    // Tag travelling alongside the multiplier pipeline.
    typedef struct packed {
        logic vld;   // a product pair is in flight
        logic quad;  // pair belongs to the imaginary accumulation
        logic upd;   // pair belongs to the coefficient update
    } mtag_t;

endpackage

// File: rtl/tcl_mul.sv
module tcl_mul #(
    parameter int WIN = 16
) (
    input  logic                        clk,
    input  logic signed [WIN-1:0]       a,
    input  logic signed [WIN-1:0]       b,
    output logic signed [2*WIN-1:0]     p
);
    logic signed [WIN-1:0]   a_q;
    logic signed [WIN-1:0]   b_q;
    logic signed [2*WIN-1:0] p_q;

    // stage 1 registers operands, stage 2 registers the product
    always_ff @(posedge clk) begin
        a_q <= a;
        b_q <= b;
        p_q <= a_q * b_q;
    end

    assign p = p_q;
endmodule

// File: rtl/tcl_coef_ram.sv
module tcl_coef_ram #(
    parameter int DEPTH = 32,
    parameter int AWID  = 5,
    parameter int WID   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_en,
    input  logic [AWID-1:0] rd_addr,
    output logic [WID-1:0]  rd_data,
    input  logic            wr_en,
    input  logic [AWID-1:0] wr_addr,
    input  logic [WID-1:0]  wr_data
);
    logic [WID-1:0]   mem [DEPTH];
    logic [DEPTH-1:0] live_q;
    logic [WID-1:0]   rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // a word never written reads as zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q <= '0;
            rd_q   <= '0;
        end else begin
            if (wr_en) begin
                live_q[wr_addr] <= 1'b1;
            end
            if (rd_en) begin
                rd_q <= live_q[rd_addr] ? mem[rd_addr] : '0;
            end
        end
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/tmux_cplx_lms.sv
module tmux_cplx_lms #(
    parameter int NTAPS    = 8,
    parameter int NUSERS   = 4,
    parameter int DW       = 16,
    parameter int FRAC     = 15,
    parameter int MU_SHIFT = 4,
    localparam int TW      = (NTAPS  > 1) ? $clog2(NTAPS)  : 1,
    localparam int UW      = (NUSERS > 1) ? $clog2(NUSERS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 train_mode,
    input  logic [UW-1:0]        user_sel,
    input  logic                 train_bit,
    output logic [TW-1:0]        smp_addr,
    input  logic signed [DW-1:0] smp_re,
    input  logic signed [DW-1:0] smp_im,
    output logic                 busy,
    output logic                 out_valid,
    output logic signed [DW-1:0] y_re,
    output logic signed [DW-1:0] y_im
);
    import tcl_pkg::*;

    localparam int DEPTH    = NUSERS * NTAPS;
    localparam int RAW      = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int FILT_LEN = 2 * NTAPS + 4;
    localparam int UPD_LEN  = 2 * NTAPS + 5;
    localparam int PASS_MAX = FILT_LEN + UPD_LEN;
    localparam int CW       = $clog2(PASS_MAX + 1);
    localparam int PW       = 2 * DW;
    localparam int AW       = PW + 2 + TW;
    localparam logic [DW-1:0] DHI = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] DLO = {1'b1, {(DW-1){1'b0}}};

    typedef struct packed {
        logic            busy;
        logic            train;
        logic            tbit;
        logic [UW-1:0]   user;
        logic [CW-1:0]   t;
        mtag_t           tag1;
        mtag_t           tag2;
        mtag_t           taga;
        logic [PW:0]     psum;
        logic [AW-1:0]   acc_re;
        logic [AW-1:0]   acc_im;
        logic [DW-1:0]   res_re;
        logic [DW-1:0]   res_im;
        logic [DW-1:0]   err;
        logic [DW-1:0]   wn_re;
        logic [DW-1:0]   wn_im;
        logic            wr_en;
        logic [RAW-1:0]  wr_addr;
        logic            vld;
        logic [DW-1:0]   y_re;
        logic [DW-1:0]   y_im;
    } st_t;

    st_t s_d, s_q;

    // saturate a (DW+1)-bit sum to DW bits
    function automatic logic [DW-1:0] clamp_s(input logic [DW:0] v);
        if (v[DW] != v[DW-1]) return v[DW] ? DLO : DHI;
        return v[DW-1:0];
    endfunction

    // accumulator scaled back to Q1.15 and saturated
    function automatic logic [DW-1:0] clamp_acc(input logic signed [AW-1:0] v);
        logic signed [AW-1:0] sh;
        sh = v >>> FRAC;
        if ((&sh[AW-1:DW-1]) || !(|sh[AW-1:DW-1])) return sh[DW-1:0];
        return sh[AW-1] ? DLO : DHI;
    endfunction

    // step-scaled update term, saturated
    function automatic logic [DW-1:0] clamp_p(input logic signed [PW-1:0] v);
        logic signed [PW-1:0] sh;
        sh = v >>> (FRAC + MU_SHIFT);
        if ((&sh[PW-1:DW-1]) || !(|sh[PW-1:DW-1])) return sh[DW-1:0];
        return sh[PW-1] ? DLO : DHI;
    endfunction

    logic signed [DW-1:0] m_a [2];
    logic signed [DW-1:0] m_b [2];
    logic signed [PW-1:0] m_p [2];
    logic signed [PW:0]   pe0, pe1;
    logic signed [PW:0]   ps_s;
    logic signed [AW-1:0] psum_x;
    logic [2*DW-1:0]      rd_data;
    logic signed [DW-1:0] w_re, w_im;
    logic [DW-1:0]        d_re, d_im;
    logic                 rd_en;
    logic [TW-1:0]        rd_tap;
    logic [TW-1:0]        sidx;
    logic [RAW-1:0]       base;
    logic                 in_filt, in_upd;
    logic [CW-1:0]        u;
    mtag_t                tag_in;

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_mul
            tcl_mul #(.WIN(DW)) u_mul (
                .clk (clk),
                .a   (m_a[g]),
                .b   (m_b[g]),
                .p   (m_p[g])
            );
        end
    endgenerate

    tcl_coef_ram #(.DEPTH(DEPTH), .AWID(RAW), .WID(2*DW)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_addr (base + RAW'(rd_tap)),
        .rd_data (rd_data),
        .wr_en   (s_q.wr_en),
        .wr_addr (s_q.wr_addr),
        .wr_data ({s_q.wn_re, s_q.wn_im})
    );

    assign w_re   = rd_data[2*DW-1:DW];
    assign w_im   = rd_data[DW-1:0];
    assign base   = RAW'(s_q.user) * RAW'(NTAPS);
    assign pe0    = m_p[0];
    assign pe1    = m_p[1];
    assign ps_s   = s_q.psum;
    assign psum_x = ps_s;
    assign d_re   = clamp_p(m_p[0]);
    assign d_im   = clamp_p(m_p[1]);

    always_comb begin
        s_d       = s_q;
        s_d.vld   = 1'b0;
        s_d.wr_en = 1'b0;
        s_d.taga  = '0;
        sidx      = '0;
        rd_en     = 1'b0;
        rd_tap    = '0;
        tag_in    = '0;
        for (int k = 0; k < 2; k++) begin
            m_a[k] = '0;
            m_b[k] = '0;
        end
        in_filt = s_q.busy && (s_q.t < CW'(FILT_LEN));
        in_upd  = s_q.busy && !in_filt;
        u       = s_q.t - CW'(FILT_LEN);

        // filtering: odd cycle = products for real part, even = imaginary
        if (in_filt && (s_q.t >= CW'(1)) && (s_q.t <= CW'(2*NTAPS))) begin
            sidx   = TW'((s_q.t - CW'(1)) >> 1);
            tag_in = '{vld: 1'b1, quad: ~s_q.t[0], upd: 1'b0};
            m_a[0] = w_re;
            m_a[1] = w_im;
            if (s_q.t[0]) begin
                m_b[0] = smp_re;
                m_b[1] = smp_im;
            end else begin
                m_b[0] = smp_im;
                m_b[1] = smp_re;
            end
        end
        if (in_filt && !s_q.t[0] && (s_q.t < CW'(2*NTAPS))) begin
            rd_en  = 1'b1;
            rd_tap = TW'(s_q.t >> 1);
        end

        // update: one tap every two cycles
        if (in_upd && !u[0] && (u < CW'(2*NTAPS))) begin
            rd_en  = 1'b1;
            rd_tap = TW'(u >> 1);
            sidx   = TW'(u >> 1);
            tag_in = '{vld: 1'b1, quad: 1'b0, upd: 1'b1};
            m_a[0] = s_q.err;
            m_a[1] = s_q.err;
            m_b[0] = smp_re;
            m_b[1] = smp_im;
        end

        s_d.tag1 = tag_in;
        s_d.tag2 = s_q.tag1;

        if (s_q.tag2.vld && !s_q.tag2.upd) begin
            s_d.taga = s_q.tag2;
            s_d.psum = s_q.tag2.quad ? (pe0 - pe1) : (pe0 + pe1);
        end
        if (s_q.taga.vld) begin
            if (s_q.taga.quad) s_d.acc_im = s_q.acc_im + psum_x;
            else               s_d.acc_re = s_q.acc_re + psum_x;
        end

        if (s_q.tag2.vld && s_q.tag2.upd) begin
            s_d.wn_re   = clamp_s({w_re[DW-1], w_re} + {d_re[DW-1], d_re});
            s_d.wn_im   = clamp_s({w_im[DW-1], w_im} + {d_im[DW-1], d_im});
            s_d.wr_en   = 1'b1;
            s_d.wr_addr = base + RAW'(TW'((u - CW'(2)) >> 1));
        end

        if (s_q.busy) s_d.t = s_q.t + CW'(1);

        if (in_filt && (s_q.t == CW'(FILT_LEN-1))) begin
            s_d.res_re = clamp_acc(s_q.acc_re);
            s_d.res_im = clamp_acc(s_d.acc_im);
            s_d.err    = clamp_s({s_q.tbit ? 1'b0 : 1'b1, s_q.tbit ? DHI : DLO}
                                 - {s_d.res_re[DW-1], s_d.res_re});
            if (!s_q.train) begin
                s_d.busy = 1'b0;
                s_d.vld  = 1'b1;
                s_d.y_re = s_d.res_re;
                s_d.y_im = s_d.res_im;
            end
        end
        if (in_upd && (u == CW'(UPD_LEN-1))) begin
            s_d.busy = 1'b0;
            s_d.vld  = 1'b1;
            s_d.y_re = s_q.res_re;
            s_d.y_im = s_q.res_im;
        end

        if (!s_q.busy && start) begin
            s_d.busy   = 1'b1;
            s_d.train  = train_mode;
            s_d.tbit   = train_bit;
            s_d.user   = user_sel;
            s_d.t      = '0;
            s_d.acc_re = '0;
            s_d.acc_im = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign smp_addr  = sidx;
    assign busy      = s_q.busy;
    assign out_valid = s_q.vld;
    assign y_re      = s_q.y_re;
    assign y_im      = s_q.y_im;
endmodule

// File: rtl/tmux_cplx_lms_chk.sv
module tmux_cplx_lms_chk #(
    parameter int NTAPS = 8,
    parameter int DW    = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          train_mode,
    input logic          busy,
    input logic          out_valid,
    input logic [DW-1:0] y_re,
    input logic [DW-1:0] y_im
);
    localparam int FILT_LEN = 2 * NTAPS + 4;
    localparam int PASS_MAX = FILT_LEN + 2 * NTAPS + 5;
    localparam int KW       = $clog2(PASS_MAX + 2) + 1;

    logic [KW-1:0] cnt_q;
    logic          mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            mode_q <= 1'b0;
        end else if (start && !busy) begin
            cnt_q  <= KW'(1);
            mode_q <= train_mode;
        end else if (busy) begin
            cnt_q  <= cnt_q + KW'(1);
        end
    end

    // R2: completion strobe lasts one cycle
    p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R2: busy only ends together with the strobe
    p_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> out_valid);

    // R3: pass length depends on the mode that was accepted
    p_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (cnt_q == (mode_q ? KW'(PASS_MAX + 1) : KW'(FILT_LEN + 1))));

    // R9: start during a pass does not restart it
    p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || out_valid));

    // R10: results only move with the strobe
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(y_re) && $stable(y_im)));
endmodule

bind tmux_cplx_lms tmux_cplx_lms_chk #(.NTAPS(NTAPS), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .train_mode (train_mode),
    .busy       (busy),
    .out_valid  (out_valid),
    .y_re       (y_re),
    .y_im       (y_im)
);

// File: tb/tmux_cplx_lms_bench.sv
module tmux_cplx_lms_bench;
    localparam int NT = 8;
    localparam int NU = 4;
    localparam int MU = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic train_mode = 1'b0;
    logic [1:0] user_sel = '0;
    logic train_bit = 1'b0;
    logic [2:0] smp_addr;
    logic signed [15:0] smp_re, smp_im;
    logic busy, out_valid;
    logic signed [15:0] y_re, y_im;

    int vre [NT];
    int vim [NT];
    int wre [NU][NT];
    int wim [NU][NT];
    int n_chk = 0;
    int n_bad = 0;
    int last_y = 0;
    int last_yi = 0;

    always #4 clk = ~clk;

    assign smp_re = 16'(vre[smp_addr]);
    assign smp_im = 16'(vim[smp_addr]);

    tmux_cplx_lms #(.NTAPS(NT), .NUSERS(NU), .DW(16), .FRAC(15), .MU_SHIFT(MU)) u_tmux_cplx_lms (
        .clk(clk), .rst_n(rst_n), .start(start), .train_mode(train_mode),
        .user_sel(user_sel), .train_bit(train_bit), .smp_addr(smp_addr),
        .smp_re(smp_re), .smp_im(smp_im), .busy(busy), .out_valid(out_valid),
        .y_re(y_re), .y_im(y_im)
    );

    function automatic int sat16(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_pass(input int usr, input bit trn, input bit tb, input bit poke, input string vtag);
        longint sre = 0;
        longint sim = 0;
        int ey, eyi, e, len;
        for (int j = 0; j < NT; j++) begin
            sre += longint'(wre[usr][j]) * vre[j] + longint'(wim[usr][j]) * vim[j];
            sim += longint'(wre[usr][j]) * vim[j] - longint'(wim[usr][j]) * vre[j];
        end
        ey  = sat16(sre >>> 15);
        eyi = sat16(sim >>> 15);
        if (trn) begin
            e = sat16((tb ? 32767 : -32768) - longint'(ey));
            for (int j = 0; j < NT; j++) begin
                wre[usr][j] = sat16(longint'(wre[usr][j]) + sat16((longint'(e) * vre[j]) >>> (15 + MU)));
                wim[usr][j] = sat16(longint'(wim[usr][j]) + sat16((longint'(e) * vim[j]) >>> (15 + MU)));
            end
        end
        len = trn ? (4 * NT + 9) : (2 * NT + 4);

        @(negedge clk);
        start = 1'b1; train_mode = trn; user_sel = 2'(usr); train_bit = tb;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0; train_mode = 1'b0; train_bit = 1'b0;
        for (int k = 0; k < len; k++) begin
            // R2 / R3: running, no strobe yet; R10: outputs held
            check(busy === 1'b1 && out_valid === 1'b0, trn ? "R3" : "R2",
                  {busy, out_valid}, 2);
            check(y_re === 16'(last_y), "R10", y_re, last_y);
            if (poke && k == 3) begin
                start = 1'b1; train_mode = 1'b1; train_bit = 1'b1;
                user_sel = 2'((usr + 1) % NU);
            end else begin
                start = 1'b0; train_mode = 1'b0;
            end
            @(posedge clk);
            @(negedge clk);
        end
        check(busy === 1'b0 && out_valid === 1'b1, trn ? "R3" : "R2", {busy, out_valid}, 1);
        check(y_re === 16'(ey), vtag, y_re, ey);
        check(y_im === 16'(eyi), vtag, y_im, eyi);
        last_y = ey; last_yi = eyi;
        @(posedge clk);
        @(negedge clk);
        // R9 when poked: no extra pass; R2 single pulse
        check(busy === 1'b0 && out_valid === 1'b0, poke ? "R9" : "R2", {busy, out_valid}, 0);
        check(y_re === 16'(last_y) && y_im === 16'(last_yi), "R10", y_re, last_y);
    endtask

    task automatic load_vec(input int kind);
        for (int i = 0; i < NT; i++) begin
            case (kind)
                0: begin vre[i] = 3000 * i - 10000; vim[i] = 9000 - 2500 * i; end
                1: begin vre[i] = (i % 2 == 1) ? 12000 : -7000; vim[i] = 4000 * (i % 3) - 5000; end
                2: begin vre[i] = 4096; vim[i] = 4096; end
                default: begin vre[i] = 28672; vim[i] = 28672; end
            endcase
        end
    endtask

    initial begin
        for (int a = 0; a < NU; a++)
            for (int j = 0; j < NT; j++) begin
                wre[a][j] = 0; wim[a][j] = 0;
            end
        load_vec(0);
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy === 1'b0 && out_valid === 1'b0, "R1", {busy, out_valid}, 0);
        check(y_re === 16'sd0 && y_im === 16'sd0, "R1", y_re, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && out_valid === 1'b0, "R1", {busy, out_valid}, 0);

        run_pass(0, 1'b0, 1'b0, 1'b0, "R1");          // zero coefficients
        for (int n = 0; n < 20; n++) run_pass(0, 1'b1, 1'b1, 1'b0, "R6");
        run_pass(0, 1'b0, 1'b0, 1'b0, "R4");
        run_pass(0, 1'b0, 1'b0, 1'b0, "R7");          // detection changed nothing
        run_pass(1, 1'b0, 1'b0, 1'b0, "R8");          // untouched user reads zero
        load_vec(1);
        for (int n = 0; n < 10; n++) run_pass(1, 1'b1, 1'b0, 1'b0, "R6");
        run_pass(1, 1'b0, 1'b0, 1'b0, "R4");
        load_vec(0);
        run_pass(0, 1'b0, 1'b0, 1'b0, "R8");          // user 0 unaffected by user 1
        run_pass(0, 1'b0, 1'b0, 1'b1, "R9");          // poke user 1 mid-pass
        load_vec(1);
        run_pass(1, 1'b0, 1'b0, 1'b0, "R9");          // user 1 not trained by poke
        load_vec(2);
        for (int n = 0; n < 100; n++) run_pass(2, 1'b1, 1'b1, 1'b0, "R6");
        for (int n = 0; n < 100; n++) run_pass(3, 1'b1, 1'b0, 1'b0, "R6");
        load_vec(3);
        run_pass(2, 1'b0, 1'b0, 1'b0, "R5");          // clamps high
        run_pass(3, 1'b0, 1'b0, 1'b0, "R5");          // clamps low
        run_pass(3, 1'b1, 1'b1, 1'b0, "R6");          // error term saturates
        run_pass(3, 1'b0, 1'b0, 1'b0, "R6");
        run_pass(2, 1'b1, 1'b0, 1'b0, "R5");

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule